// File: doc/BRIEF.md
# Serial ADC Frame Controller

This block is the system-side master for a four-input, 12-bit serial converter that performs one conversion per chip-select frame. When a start request is accepted it lowers chip select, which makes the converter sample and convert. It then clocks sixteen serial-clock cycles, shifting a 16-bit control word out on the data-in line and collecting the 16-bit reply from the data-out line. After the last bit it raises chip select and presents the 2-bit channel tag and the 12-bit result to the system on a valid/ready port.

All interface gaps are counted in system-clock cycles. Each count comes from a time in picoseconds and is rounded up, so no gap is shorter than its minimum. The gaps are the chip-select-to-first-edge lead, the settle time after the sixteenth falling edge and the quiet time between frames. The serial-clock half period comes from a divider input, clamped to the range the converter allows. A control-word bit tells the controller whether the converter is sending two's complement. When it is, the result MSB is flipped, so downstream logic always receives unsigned binary.

Top module: `adc_frame_ctrl`

## Requirements
- R1: While chip select (cs_n_o) is high, sclk_o is 1 and din_o is 0. Chip select falls only while sclk_o is high, and each frame contains exactly 16 sclk_o falling edges.
- R2: The control word leaves on din_o MSB first. din_o changes only on sclk_o rising edges, so the bits sampled on the 16 falling edges equal ctrl_i as it was at acceptance.
- R3: dout_i is sampled at each of the 16 sclk_o falling edges, and the first bit is the one present when chip select falls. In the 16-bit word received MSB first, bits [13:12] appear on res_chan_o and bits [11:0] are the raw result.
- R4: res_lead_err_o is 1 when bit 15 or bit 14 of the received word is 1, and 0 otherwise.
- R5: Bit CODING_BIT (default 4) of the accepted control word selects the coding. A 1 passes the raw result unchanged. A 0 marks it as two's complement, and res_data_o is then the raw result with bit 11 inverted.
- R6: Each sclk_o high and low phase lasts H system cycles. H is div_i clamped to [ceil(SCLK_MIN_PS/2/CLK_PS), floor(SCLK_MAX_PS/2/CLK_PS)], and div_i is sampled at acceptance.
- R7: The time from chip select falling to the first sclk_o falling edge is at least TLEAD_PS. The time from the 16th sclk_o falling edge to chip select rising is at least TTRAIL_PS.
- R8: Between chip select rising and the next fall, at least TQUIET_PS passes. A start request held high during that gap is not taken early.
- R9: A result stays on res_valid_o, res_chan_o, res_data_o and res_lead_err_o until res_ready_i is seen high. While a result is pending, start_ready_o is 0 and start requests are ignored.
- R10: After reset, cs_n_o=1, sclk_o=1, din_o=0, res_valid_o=0 and start_ready_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to run one conversion frame |
| ctrl_i | input | 16 | Control word to send in the frame |
| div_i | input | DIV_W | Requested serial-clock half period in system cycles |
| start_ready_o | output | 1 | A start request would be accepted this cycle |
| cs_n_o | output | 1 | Chip select to the converter, active low |
| sclk_o | output | 1 | Serial clock to the converter |
| din_o | output | 1 | Serial control data to the converter |
| dout_i | input | 1 | Serial result data from the converter |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Result consumer ready |
| res_chan_o | output | 2 | Channel tag of the result |
| res_data_o | output | 12 | Result, unsigned binary |
| res_lead_err_o | output | 1 | A leading bit of the frame was not zero |

## Verification
The hardest situations to reach from the ports are the two reasons a start is refused while the block looks idle: the quiet gap still running, and an unaccepted result. For the first, the bench holds start_i high with res_ready_i high through two frames, so the second chip-select fall comes at the earliest moment the block allows, and measures that gap. For the second, it holds res_ready_i low after a frame and keeps requesting starts. It then confirms that no chip-select edge appears and the result stays put. A bench-side converter model drives dout_i and records din_o, so every edge spacing is checked in real time.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

  localparam int FRAME_BITS = 16;
  localparam int CHAN_W     = 2;
  localparam int RES_W      = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_TRAIL
  } fr_state_e;

  // cycles needed to cover a time, rounded up, never below one
  function automatic int cyc_ceil(input int ps, input int clk_ps);
    int c;
    c = (ps + clk_ps - 1) / clk_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

  // cycles that fit in a time, rounded down, never below one
  function automatic int cyc_floor(input int ps, input int clk_ps);
    int c;
    c = ps / clk_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/adc_rst_sync.sv
module adc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/adc_gap_timer.sv
module adc_gap_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);

  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i)));

endmodule

// File: rtl/adc_frame_shifter.sv
module adc_frame_shifter
  import adc_frame_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic [FRAME_BITS-1:0] word_i,
  input  logic                  adv_i,
  input  logic                  cap_i,
  input  logic                  dout_i,
  output logic                  din_o,
  output logic [FRAME_BITS-1:0] rx_o
);

  logic [FRAME_BITS-1:0] tx_q, tx_d, rx_q, rx_d;
  logic                  tx_en, rx_en;

  always_comb begin
    tx_en = load_i || adv_i;
    tx_d  = load_i ? word_i : {tx_q[FRAME_BITS-2:0], 1'b0};
    rx_en = cap_i;
    rx_d  = {rx_q[FRAME_BITS-2:0], dout_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (tx_en) tx_q <= tx_d;
      if (rx_en) rx_q <= rx_d;
    end
  end

  assign din_o = tx_q[FRAME_BITS-1];
  assign rx_o  = rx_q;

  // R2
  din_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !load_i) |=> $stable(din_o));

endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt
  import adc_frame_pkg::*;
#(
  parameter bit NORMALIZE = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push_i,
  input  logic [FRAME_BITS-1:0] raw_i,
  input  logic                  binary_i,
  output logic                  valid_o,
  input  logic                  ready_i,
  output logic [CHAN_W-1:0]     chan_o,
  output logic [RES_W-1:0]      data_o,
  output logic                  err_o
);

  logic [RES_W-1:0]  norm;
  logic              valid_q, valid_d;
  logic [CHAN_W-1:0] chan_q;
  logic [RES_W-1:0]  data_q;
  logic              err_q;

  generate
    if (NORMALIZE) begin : g_norm
      assign norm = binary_i ? raw_i[RES_W-1:0]
                             : {~raw_i[RES_W-1], raw_i[RES_W-2:0]};
    end else begin : g_pass
      assign norm = raw_i[RES_W-1:0];
    end
  endgenerate

  always_comb begin
    valid_d = valid_q;
    if (push_i)                valid_d = 1'b1;
    else if (valid_q && ready_i) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      data_q <= '0;
      err_q  <= 1'b0;
    end else if (push_i) begin
      chan_q <= raw_i[RES_W+CHAN_W-1:RES_W];
      data_q <= norm;
      err_q  <= |raw_i[FRAME_BITS-1:RES_W+CHAN_W];
    end
  end

  assign valid_o = valid_q;
  assign chan_o  = chan_q;
  assign data_o  = data_q;
  assign err_o   = err_q;

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(chan_o) && $stable(err_o)));

  // R9
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !valid_q);

  // R5
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> (data_o[RES_W-2:0] == $past(raw_i[RES_W-2:0])));

endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_frame_pkg::*;
#(
  parameter int CLK_PS      = 5000,
  parameter int TLEAD_PS    = 10000,
  parameter int TTRAIL_PS   = 20000,
  parameter int TQUIET_PS   = 50000,
  parameter int SCLK_MIN_PS = 50000,
  parameter int SCLK_MAX_PS = 100000000,
  parameter int DIV_W       = 16,
  parameter int CODING_BIT  = 4,
  parameter bit NORMALIZE   = 1'b1
) (
  input  logic                  clk,
  input  logic                  arst_n,
  input  logic                  start_i,
  input  logic [FRAME_BITS-1:0] ctrl_i,
  input  logic [DIV_W-1:0]      div_i,
  output logic                  start_ready_o,
  output logic                  cs_n_o,
  output logic                  sclk_o,
  output logic                  din_o,
  input  logic                  dout_i,
  output logic                  res_valid_o,
  input  logic                  res_ready_i,
  output logic [CHAN_W-1:0]     res_chan_o,
  output logic [RES_W-1:0]      res_data_o,
  output logic                  res_lead_err_o
);

  localparam int LEAD_CYC  = cyc_ceil(TLEAD_PS, CLK_PS);
  localparam int TRAIL_CYC = cyc_ceil(TTRAIL_PS, CLK_PS);
  localparam int QUIET_CYC = cyc_ceil(TQUIET_PS, CLK_PS);
  localparam int HALF_MIN  = cyc_ceil(SCLK_MIN_PS / 2, CLK_PS);
  localparam int HALF_MAX_RAW = cyc_floor(SCLK_MAX_PS / 2, CLK_PS);
  localparam int HALF_MAX  = (HALF_MAX_RAW < HALF_MIN) ? HALF_MIN : HALF_MAX_RAW;
  localparam int BIT_W     = $clog2(FRAME_BITS);

  localparam logic [DIV_W-1:0] HALF_MIN_V  = DIV_W'(HALF_MIN);
  localparam logic [DIV_W-1:0] HALF_MAX_V  = DIV_W'(HALF_MAX);
  localparam logic [DIV_W-1:0] LEAD_LD     = DIV_W'(LEAD_CYC - 1);
  localparam logic [DIV_W-1:0] TRAIL_LD    = DIV_W'(TRAIL_CYC - 1);
  localparam logic [DIV_W-1:0] QUIET_LD    = DIV_W'(QUIET_CYC - 1);
  localparam logic [BIT_W-1:0] LAST_BIT    = BIT_W'(FRAME_BITS - 1);

  logic rst_n;

  adc_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  fr_state_e         state_q, state_d;
  logic              cs_q, cs_d;
  logic              sclk_q, sclk_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [DIV_W-1:0]  half_q, half_d, half_c;
  logic              bin_q, bin_d;

  logic              tmr_load, tmr_done;
  logic [DIV_W-1:0]  tmr_val;
  logic              q_load, q_done;
  logic              sh_load, sh_adv, sh_cap;
  logic              push;
  logic [FRAME_BITS-1:0] rx_word;
  logic              accept;

  adc_gap_timer #(.W(DIV_W)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  adc_gap_timer #(.W(DIV_W)) u_quiet (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (q_load),
    .load_val_i (QUIET_LD),
    .done_o     (q_done)
  );

  adc_frame_shifter u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (sh_load),
    .word_i (ctrl_i),
    .adv_i  (sh_adv),
    .cap_i  (sh_cap),
    .dout_i (dout_i),
    .din_o  (din_o),
    .rx_o   (rx_word)
  );

  adc_result_fmt #(.NORMALIZE(NORMALIZE)) u_fmt (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_i   (push),
    .raw_i    (rx_word),
    .binary_i (bin_q),
    .valid_o  (res_valid_o),
    .ready_i  (res_ready_i),
    .chan_o   (res_chan_o),
    .data_o   (res_data_o),
    .err_o    (res_lead_err_o)
  );

  // divider clamp to the legal serial-clock range
  always_comb begin
    if (div_i < HALF_MIN_V)      half_c = HALF_MIN_V;
    else if (div_i > HALF_MAX_V) half_c = HALF_MAX_V;
    else                         half_c = div_i;
  end

  assign start_ready_o = (state_q == ST_IDLE) && q_done && !res_valid_o;
  assign accept        = start_i && start_ready_o;

  always_comb begin
    state_d  = state_q;
    cs_d     = cs_q;
    sclk_d   = sclk_q;
    bit_d    = bit_q;
    half_d   = half_q;
    bin_d    = bin_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    q_load   = 1'b0;
    sh_load  = 1'b0;
    sh_adv   = 1'b0;
    sh_cap   = 1'b0;
    push     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          cs_d     = 1'b0;
          state_d  = ST_LEAD;
          tmr_load = 1'b1;
          tmr_val  = LEAD_LD;
          sh_load  = 1'b1;
          half_d   = half_c;
          bin_d    = ctrl_i[CODING_BIT];
          bit_d    = '0;
        end
      end
      ST_LEAD: begin
        if (tmr_done) begin
          sclk_d   = 1'b0;
          sh_cap   = 1'b1;
          state_d  = ST_LOW;
          tmr_load = 1'b1;
          tmr_val  = half_q - 1'b1;
        end
      end
      ST_LOW: begin
        if (tmr_done) begin
          sclk_d   = 1'b1;
          sh_adv   = 1'b1;
          tmr_load = 1'b1;
          bit_d    = bit_q + 1'b1;
          if (bit_q == LAST_BIT) begin
            state_d = ST_TRAIL;
            tmr_val = TRAIL_LD;
          end else begin
            state_d = ST_HIGH;
            tmr_val = half_q - 1'b1;
          end
        end
      end
      ST_HIGH: begin
        if (tmr_done) begin
          sclk_d   = 1'b0;
          sh_cap   = 1'b1;
          state_d  = ST_LOW;
          tmr_load = 1'b1;
          tmr_val  = half_q - 1'b1;
        end
      end
      ST_TRAIL: begin
        if (tmr_done) begin
          cs_d    = 1'b1;
          state_d = ST_IDLE;
          q_load  = 1'b1;
          push    = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cs_q    <= 1'b1;
      sclk_q  <= 1'b1;
      bit_q   <= '0;
      half_q  <= HALF_MIN_V;
      bin_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      cs_q    <= cs_d;
      sclk_q  <= sclk_d;
      bit_q   <= bit_d;
      if (accept) begin
        half_q <= half_d;
        bin_q  <= bin_d;
      end
    end
  end

  assign cs_n_o = cs_q;
  assign sclk_o = sclk_q;

  // R1
  cs_fall_sclk_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> sclk_o);

  // R1
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> (sclk_o && !din_o));

  // R2
  din_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_o) |-> $stable(din_o));

  // R8
  quiet_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> $past(q_done));

  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(res_valid_o) && res_valid_o) |-> $stable(cs_n_o) || !cs_n_o);

endmodule

// File: tb/sim_adc_frame_ctrl.sv
`timescale 1ns/1ps
module sim_adc_frame_ctrl;

  localparam real TCLK = 5.0;
  localparam int  HMIN = 5;
  localparam int  HMAX = 40;

  logic        clk = 1'b0;
  logic        arst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] ctrl_i = '0;
  logic [15:0] div_i = 16'd5;
  logic        start_ready_o, cs_n_o, sclk_o, din_o, dout_i;
  logic        res_valid_o;
  logic        res_ready_i = 1'b0;
  logic [1:0]  res_chan_o;
  logic [11:0] res_data_o;
  logic        res_lead_err_o;

  always #2.5 clk = ~clk;

  adc_frame_ctrl #(.SCLK_MAX_PS(400000)) u0 (
    .clk(clk), .arst_n(arst_n), .start_i(start_i), .ctrl_i(ctrl_i), .div_i(div_i),
    .start_ready_o(start_ready_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .din_o(din_o),
    .dout_i(dout_i), .res_valid_o(res_valid_o), .res_ready_i(res_ready_i),
    .res_chan_o(res_chan_o), .res_data_o(res_data_o), .res_lead_err_o(res_lead_err_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // converter model and edge monitor
  logic [15:0] adc_word = '0;
  logic [15:0] tx = '0;
  logic [15:0] din_rx = '0;
  logic        cs_prev = 1'b1, sclk_prev = 1'b1;
  realtime     t_csf = 0, t_csr = -1000, t_lastfall = 0, t_prev = 0;
  realtime     lead_t = 0, trail_t = 0, gap_t = 0, ph_min = 0, ph_max = 0;
  int          nfall = 0, frame_falls = 0, n_csf = 0;

  assign dout_i = tx[15];

  always @(cs_n_o or sclk_o) begin
    realtime t;
    t = $realtime;
    if (cs_n_o !== cs_prev) begin
      if (cs_n_o == 1'b0) begin
        gap_t  = t - t_csr;
        t_csf  = t;
        nfall  = 0;
        ph_min = 1.0e9;
        ph_max = 0;
        tx     = adc_word;
        n_csf++;
      end else begin
        t_csr       = t;
        trail_t     = t - t_lastfall;
        frame_falls = nfall;
      end
      cs_prev = cs_n_o;
    end
    if (sclk_o !== sclk_prev) begin
      if (!cs_n_o) begin
        if (sclk_o == 1'b0) begin
          nfall++;
          din_rx = {din_rx[14:0], din_o};
          if (nfall == 1) lead_t = t - t_csf;
          else begin
            if (t - t_prev < ph_min) ph_min = t - t_prev;
            if (t - t_prev > ph_max) ph_max = t - t_prev;
          end
          t_lastfall = t;
          tx = {tx[14:0], 1'b0};
        end else begin
          if (t - t_prev < ph_min) ph_min = t - t_prev;
          if (t - t_prev > ph_max) ph_max = t - t_prev;
        end
        t_prev = t;
      end
      sclk_prev = sclk_o;
    end
  end

  // {ctrl, div, chan, data, lead}
  localparam logic [47:0] VECS [7] = '{
    {16'h8310, 16'd5,    2'd1, 12'hABC, 2'd0},
    {16'h8300, 16'd6,    2'd2, 12'h800, 2'd0},
    {16'hFFFF, 16'd1,    2'd3, 12'hFFF, 2'd0},
    {16'h0000, 16'd7,    2'd0, 12'h000, 2'd0},
    {16'h1234, 16'd5,    2'd2, 12'h555, 2'd2},
    {16'hA5E0, 16'd9,    2'd1, 12'h7FF, 2'd1},
    {16'h4C1B, 16'h0100, 2'd3, 12'h123, 2'd0}
  };

  function automatic int exp_half(input logic [15:0] d);
    if (d < HMIN) return HMIN;
    if (d > HMAX) return HMAX;
    return int'(d);
  endfunction

  function automatic logic [11:0] exp_data(input logic [15:0] c, input logic [11:0] d);
    return c[4] ? d : (d ^ 12'h800);
  endfunction

  task automatic wait_valid();
    while (!res_valid_o) @(negedge clk);
  endtask

  task automatic pulse_ready();
    res_ready_i = 1'b1;
    @(negedge clk);
    res_ready_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_frame(input logic [47:0] v);
    logic [15:0] c, d;
    logic [1:0]  ch, ld;
    logic [11:0] dat;
    int          h;
    {c, d, ch, dat, ld} = v;
    h = exp_half(d);
    adc_word = {ld, ch, dat};
    ctrl_i = c;
    div_i  = d;
    while (!start_ready_o) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    ctrl_i  = 16'h0F0F;
    div_i   = 16'd3;
    wait_valid();
    chk(res_chan_o == ch, "R3", "channel", res_chan_o, ch);
    chk(res_data_o == exp_data(c, dat), "R5", "data", res_data_o, exp_data(c, dat));
    chk(res_lead_err_o == (ld != 0), "R4", "lead flag", res_lead_err_o, ld != 0);
    chk(din_rx == c, "R2", "control word seen", din_rx, c);
    chk(frame_falls == 16, "R1", "falling edges", frame_falls, 16);
    chk(lead_t >= 10.0, "R7", "lead ns", longint'(lead_t), 10);
    chk(trail_t >= 20.0, "R7", "trail ns", longint'(trail_t), 20);
    chk(ph_min == h * TCLK, "R6", "min phase ns", longint'(ph_min), longint'(h * TCLK));
    chk(ph_max == h * TCLK, "R6", "max phase ns", longint'(ph_max), longint'(h * TCLK));
    pulse_ready();
  endtask

  initial begin
    #(200000 * TCLK);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(cs_n_o == 1'b1, "R10", "cs_n", cs_n_o, 1);
    chk(sclk_o == 1'b1, "R10", "sclk", sclk_o, 1);
    chk(din_o == 1'b0, "R10", "din", din_o, 0);
    chk(res_valid_o == 1'b0, "R10", "valid", res_valid_o, 0);
    chk(start_ready_o == 1'b1, "R10", "start_ready", start_ready_o, 1);

    for (int i = 0; i < 7; i++) run_frame(VECS[i]);

    // R9 backpressure: result held, starts refused
    adc_word = {2'b00, 2'd2, 12'h3C5};
    ctrl_i = 16'h0010;
    div_i  = 16'd5;
    while (!start_ready_o) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_valid();
    begin
      int csf0;
      csf0 = n_csf;
      start_i = 1'b1;
      repeat (60) @(negedge clk);
      chk(start_ready_o == 1'b0, "R9", "start_ready while pending", start_ready_o, 0);
      chk(n_csf == csf0, "R9", "frames started while pending", n_csf - csf0, 0);
      chk(cs_n_o == 1'b1, "R9", "cs_n while pending", cs_n_o, 1);
      chk(res_valid_o == 1'b1, "R9", "valid held", res_valid_o, 1);
      chk(res_data_o == 12'h3C5, "R9", "data held", res_data_o, 12'h3C5);
      start_i = 1'b0;
    end
    pulse_ready();

    // R8 back-to-back frames with start held high
    adc_word = {2'b00, 2'd1, 12'h0A5};
    ctrl_i = 16'h0010;
    div_i  = 16'd5;
    res_ready_i = 1'b1;
    while (!start_ready_o) @(negedge clk);
    begin
      int csf0;
      csf0 = n_csf;
      start_i = 1'b1;
      while (n_csf < csf0 + 2) @(negedge clk);
      start_i = 1'b0;
      chk(gap_t >= 50.0, "R8", "quiet gap ns", longint'(gap_t), 50);
      chk(gap_t <= 70.0, "R8", "quiet gap upper ns", longint'(gap_t), 50);
    end
    while (cs_n_o == 1'b0) @(negedge clk);
    @(negedge clk);
    chk(frame_falls == 16, "R1", "falling edges back-to-back", frame_falls, 16);
    res_ready_i = 1'b0;
    repeat (20) @(negedge clk);
    chk(cs_n_o == 1'b1 && sclk_o == 1'b1 && din_o == 1'b0, "R1", "idle pins",
        {cs_n_o, sclk_o, din_o}, 3'b110);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule